// File: doc/BRIEF.md
# Neighborhood Window Buffer for Cellular Automaton Rules

This block sits between the source state memory and the rule processing elements of a cellular automaton engine. It takes one memory word per accepted transfer, treats the word as a vertical column of cells (one cell per bit), and keeps the most recent `SPAN` columns in parallel shift registers. For every row of the word it presents the full square neighborhood: the cell itself, its horizontal neighbors from the older and newer columns, and its vertical neighbors from the rows above and below in the same window.

Words arrive on a valid/ready stream, and neighborhoods leave on a second valid/ready stream. The input is back-pressured when a complete window is waiting and the consumer is not ready. When the consumer is ready, the window can advance on every clock. A window is offered once for each word that completes it. Rows beyond the top and bottom of the word read as zero, which gives a null boundary. A synchronous clear empties the window between sweeps, so that the columns of one sweep never reach the neighborhoods of the next.

Top module: `nbhd_window`

## Requirements
- R1: A word is accepted on a clock edge where `in_valid` and `in_ready` are both high. `in_ready` is high exactly when `clr` is low and either no window is offered (`out_valid` low) or `out_ready` is high.
- R2: On acceptance the word becomes column 0, the previous column 0 becomes column 1, the previous column 1 becomes column 2, and the oldest column is discarded.
- R3: `out_valid` stays low until `SPAN` (3) words have been accepted since reset or the last clear. It rises in the cycle after the edge that accepts the third word.
- R4: Each window is offered once. After an output handshake in which no new word is accepted, `out_valid` is low in the next cycle.
- R5: While `out_valid` is high and `out_ready` is low, `out_valid` stays high and `out_taps` stays unchanged.
- R6: The neighborhood of row r occupies `out_taps[r*9 +: 9]`. Within it, bit `3*dr + dc` holds the cell of row `r-1+dr` (dr = 0..2) in column `dc` (dc = 0 newest, 2 oldest). The centre cell is bit 4.
- R7: A tap whose source row is below 0 or above `ROWS-1` reads 0. With all cells set to one, row 0 reads 9'h1F8 and row 31 reads 9'h03F.
- R8: While `clr` is high, `in_ready` is low. After a clock edge with `clr` high, `out_valid` is low and every bit of `out_taps` is 0 until the next accepted word.
- R9: During and after reset, `in_ready` is 1, `out_valid` is 0 and `out_taps` is all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| clr | input | 1 | Synchronous window clear at the start of a sweep |
| in_valid | input | 1 | Source word is present |
| in_ready | output | 1 | Window can take a word this cycle |
| in_word | input | ROWS (32) | Source word, bit r is the cell in row r |
| out_valid | output | 1 | A complete, not yet consumed window is offered |
| out_ready | input | 1 | Consumer takes the offered window |
| out_taps | output | ROWS*9 (288) | Per-row 3x3 neighborhoods, layout as in R6 |

## Verification
The bench fills the window with all-ones words so that the zero boundary shows at rows 0 and 31. If the edge rows wrapped around or read a neighbor that does not exist, those two slices would come out as 9'h1FF. It holds `out_ready` low while a word waits on the input. A design that let the word in anyway would change the offered window under the consumer or lose the window. It drops `out_ready` after a single handshake with no new word. A design without a consumed flag would offer the same window twice. A single set bit, tracked to the oldest column, pins down the tap ordering. A clear issued in the middle of a stream must leave the taps at zero, and the next valid window must contain only words accepted after the clear.

// File: rtl/nbw_pkg.sv
package nbw_pkg;
  localparam int unsigned NBW_ROWS = 32;
  localparam int unsigned NBW_SPAN = 3;

  function automatic int unsigned tap_pos(int unsigned dr, int unsigned dc, int unsigned span);
    return dr * span + dc;
  endfunction
endpackage

// File: rtl/nbw_flow_ctrl.sv
module nbw_flow_ctrl #(
  parameter int unsigned SPAN = 3
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic in_valid,
  input  logic out_ready,
  output logic in_ready,
  output logic accept,
  output logic out_valid
);
  localparam int unsigned CW = $clog2(SPAN + 1);
  localparam logic [CW-1:0] FULL = CW'(SPAN);

  logic [CW-1:0] fill;
  logic          fresh;

  assign out_valid = (fill == FULL) && fresh;
  assign in_ready  = !clr && (!out_valid || out_ready);
  assign accept    = in_valid && in_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fill  <= '0;
      fresh <= 1'b0;
    end else if (clr) begin
      fill  <= '0;
      fresh <= 1'b0;
    end else if (accept) begin
      if (fill != FULL) fill <= fill + 1'b1;
      fresh <= 1'b1;
    end else if (out_valid && out_ready) begin
      fresh <= 1'b0;
    end
  end

  a_r3_rise_after_accept: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(out_valid) |-> $past(accept));
  a_r4_offered_once: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_ready && !accept) |=> !out_valid);
  a_r5_hold_valid: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready && !clr) |=> out_valid);
  a_r8_clear_drops: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> !out_valid);
endmodule

// File: rtl/nbw_col_bank.sv
module nbw_col_bank #(
  parameter int unsigned ROWS = 32,
  parameter int unsigned SPAN = 3
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 clr,
  input  logic                 accept,
  input  logic [ROWS-1:0]      in_word,
  output logic [SPAN*ROWS-1:0] cols_flat
);
  logic [ROWS-1:0] col_q [SPAN];

  genvar k;
  generate
    for (k = 0; k < SPAN; k++) begin : g_col
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          col_q[k] <= '0;
        end else if (clr) begin
          col_q[k] <= '0;
        end else if (accept) begin
          if (k == 0) col_q[k] <= in_word;
          else        col_q[k] <= col_q[(k == 0) ? 0 : k-1];
        end
      end
      assign cols_flat[k*ROWS +: ROWS] = col_q[k];

      if (k > 0) begin : g_chk
        a_r2_column_moves: assert property (@(posedge clk) disable iff (!rst_n)
          accept |=> col_q[k] == $past(col_q[k-1]));
      end
    end
  endgenerate

  a_r2_entry_word: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> col_q[0] == $past(in_word));
  a_r5_idle_stable: assert property (@(posedge clk) disable iff (!rst_n)
    (!accept && !clr) |=> $stable(cols_flat));
endmodule

// File: rtl/nbw_tap_map.sv
module nbw_tap_map
  import nbw_pkg::*;
#(
  parameter int unsigned ROWS = 32,
  parameter int unsigned SPAN = 3
) (
  input  logic [SPAN*ROWS-1:0]      cols_flat,
  output logic [ROWS*SPAN*SPAN-1:0] taps
);
  localparam int HALO = SPAN / 2;
  localparam int NB   = SPAN * SPAN;

  genvar r, dr, dc;
  generate
    for (r = 0; r < ROWS; r++) begin : g_row
      for (dr = 0; dr < SPAN; dr++) begin : g_dr
        for (dc = 0; dc < SPAN; dc++) begin : g_dc
          localparam int SRC = r + dr - HALO;
          localparam int BIT = r * NB + int'(tap_pos(dr, dc, SPAN));
          if (SRC < 0 || SRC >= ROWS) begin : g_edge
            assign taps[BIT] = 1'b0;
          end else begin : g_in
            assign taps[BIT] = cols_flat[dc*ROWS + SRC];
          end
        end
      end
    end
  endgenerate
endmodule

// File: rtl/nbhd_window.sv
module nbhd_window
  import nbw_pkg::*;
#(
  parameter int unsigned ROWS = NBW_ROWS,
  parameter int unsigned SPAN = NBW_SPAN
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      clr,
  input  logic                      in_valid,
  output logic                      in_ready,
  input  logic [ROWS-1:0]           in_word,
  output logic                      out_valid,
  input  logic                      out_ready,
  output logic [ROWS*SPAN*SPAN-1:0] out_taps
);
  logic                 accept;
  logic [SPAN*ROWS-1:0] cols_flat;

  nbw_flow_ctrl #(.SPAN(SPAN)) flow_i (
    .clk(clk), .rst_n(rst_n), .clr(clr), .in_valid(in_valid),
    .out_ready(out_ready), .in_ready(in_ready), .accept(accept),
    .out_valid(out_valid)
  );

  nbw_col_bank #(.ROWS(ROWS), .SPAN(SPAN)) bank_i (
    .clk(clk), .rst_n(rst_n), .clr(clr), .accept(accept),
    .in_word(in_word), .cols_flat(cols_flat)
  );

  nbw_tap_map #(.ROWS(ROWS), .SPAN(SPAN)) taps_i (
    .cols_flat(cols_flat), .taps(out_taps)
  );

  a_r1_stall_blocks: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready && !clr) |=> $stable(out_taps));
endmodule

// File: tb/nbhd_window_tb_top.sv
module nbhd_window_tb_top;
  localparam int ROWS = 32;
  localparam int SPAN = 3;
  localparam int NT   = ROWS * SPAN * SPAN;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic clr = 1'b0;
  logic in_valid = 1'b0;
  logic in_ready;
  logic [ROWS-1:0] in_word = '0;
  logic out_valid;
  logic out_ready = 1'b0;
  logic [NT-1:0] out_taps;

  always #4 clk = ~clk;

  nbhd_window dut_i (
    .clk(clk), .rst_n(rst_n), .clr(clr), .in_valid(in_valid),
    .in_ready(in_ready), .in_word(in_word), .out_valid(out_valid),
    .out_ready(out_ready), .out_taps(out_taps)
  );

  int n_chk = 0;
  int n_bad = 0;
  logic [NT-1:0]   sb_q [$];
  logic [ROWS-1:0] m_col [SPAN];
  int              m_fill = 0;
  bit              m_fresh = 1'b0;
  logic [31:0]     lfsr = 32'h1ACE_B00C;

  task automatic chk(string req, logic [NT-1:0] act, logic [NT-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [NT-1:0] model_taps();
    logic [NT-1:0] t = '0;
    for (int r = 0; r < ROWS; r++)
      for (int dr = 0; dr < 3; dr++)
        for (int dc = 0; dc < 3; dc++) begin
          int sr = r - 1 + dr;
          if (sr >= 0 && sr < ROWS) t[r*9 + 3*dr + dc] = m_col[dc][sr];
        end
    return t;
  endfunction

  function automatic logic [31:0] step(logic [31:0] x);
    logic [31:0] y = x;
    y ^= y << 13; y ^= y >> 17; y ^= y << 5;
    return y;
  endfunction

  // monitor / scoreboard
  always @(negedge clk) begin
    if (!rst_n) begin
      m_fill = 0; m_fresh = 1'b0; sb_q.delete();
      for (int k = 0; k < SPAN; k++) m_col[k] = '0;
    end else begin
      bit ev, er, acc;
      ev  = (m_fill == SPAN) && m_fresh;
      er  = !clr && (!ev || out_ready);
      acc = in_valid && er;
      chk("R4 out_valid", NT'(out_valid), NT'(ev));
      chk("R1 in_ready", NT'(in_ready), NT'(er));
      if (ev && out_ready) begin
        if (sb_q.size() == 0) chk("R6 window", out_taps, ~out_taps);
        else chk("R6 window", out_taps, sb_q.pop_front());
      end
      if (clr) begin
        m_fill = 0; m_fresh = 1'b0; sb_q.delete();
        for (int k = 0; k < SPAN; k++) m_col[k] = '0;
      end else if (acc) begin
        m_col[2] = m_col[1]; m_col[1] = m_col[0]; m_col[0] = in_word;
        if (m_fill < SPAN) m_fill++;
        m_fresh = 1'b1;
        if (m_fill == SPAN) sb_q.push_back(model_taps());
      end else if (ev && out_ready) begin
        m_fresh = 1'b0;
      end
    end
  end

  task automatic put_word(logic [ROWS-1:0] w);
    @(posedge clk); #1;
    in_valid = 1'b1; in_word = w;
    forever begin
      @(negedge clk);
      if (in_ready) break;
    end
    @(posedge clk); #1;
    in_valid = 1'b0;
  endtask

  task automatic run_main();
    logic [NT-1:0] held;
    bit took;
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk("R9 reset in_ready", NT'(in_ready), NT'(1));
    chk("R9 reset out_valid", NT'(out_valid), NT'(0));
    chk("R9 reset taps", out_taps, '0);
    @(posedge clk); #1 rst_n = 1'b1;

    put_word('1); put_word('1);
    @(negedge clk);
    chk("R3 two words", NT'(out_valid), NT'(0));
    put_word('1);
    @(negedge clk);
    chk("R3 three words", NT'(out_valid), NT'(1));
    chk("R7 top row", NT'(out_taps[0 +: 9]), NT'(9'h1F8));
    chk("R7 bottom row", NT'(out_taps[31*9 +: 9]), NT'(9'h03F));
    chk("R6 inner row", NT'(out_taps[5*9 +: 9]), NT'(9'h1FF));

    held = out_taps;
    @(posedge clk); #1 in_valid = 1'b1; in_word = 32'h0000_0F0F;
    repeat (3) begin
      @(negedge clk);
      chk("R1 stalled", NT'(in_ready), NT'(0));
      chk("R5 held valid", NT'(out_valid), NT'(1));
      chk("R5 held taps", out_taps, held);
    end
    @(posedge clk); #1 out_ready = 1'b1;
    @(posedge clk); #1 in_valid = 1'b0;
    @(negedge clk);
    chk("R2 new window", NT'(out_valid), NT'(1));
    chk("R2 newest column", NT'(out_taps[1*9 + 3]), NT'(1));
    chk("R2 newest column zero", NT'(out_taps[5*9 + 3]), NT'(0));
    @(posedge clk); #1 out_ready = 1'b0;
    @(negedge clk);
    chk("R4 consumed once", NT'(out_valid), NT'(0));

    @(posedge clk); #1 clr = 1'b1; in_valid = 1'b1; in_word = '1;
    @(negedge clk);
    chk("R8 clear blocks input", NT'(in_ready), NT'(0));
    @(posedge clk); #1 clr = 1'b0; in_valid = 1'b0;
    @(negedge clk);
    chk("R8 cleared valid", NT'(out_valid), NT'(0));
    chk("R8 cleared taps", out_taps, '0);

    put_word(32'h0000_0400); put_word('0); put_word('0);
    @(negedge clk);
    chk("R6 centre row oldest", NT'(out_taps[10*9 +: 9]), NT'(9'h020));
    chk("R6 row above", NT'(out_taps[9*9 +: 9]), NT'(9'h100));
    chk("R6 row below", NT'(out_taps[11*9 +: 9]), NT'(9'h004));
    @(posedge clk); #1 out_ready = 1'b1;
    @(posedge clk); #1 out_ready = 1'b0;

    for (int i = 0; i < 4000; i++) begin
      @(negedge clk); took = in_valid && in_ready;
      @(posedge clk); #1;
      lfsr = step(lfsr);
      if (took || !in_valid) begin
        in_valid = lfsr[3] | lfsr[9];
        in_word  = step(lfsr ^ 32'h5A5A_1234);
      end
      out_ready = lfsr[17] | lfsr[22];
      clr = (lfsr[31:25] == 7'd0);
    end
    @(posedge clk); #1 clr = 1'b0; in_valid = 1'b0; out_ready = 1'b1;
    repeat (4) @(posedge clk);
  endtask

  initial begin
    fork
      run_main();
      begin
        repeat (200000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog actual=running expected=finished");
      end
    join_any
    disable fork;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule